// File: doc/BRIEF.md
# Oversampled SPI Byte Slave

This block is an SPI slave (mode 0) that lives entirely in a fast system clock domain. The serial clock, data-in and active-low select lines are treated as ordinary inputs: each passes through a two-flop synchroniser, and serial clock edges are found by comparing the two most recent synchronised samples. The system clock must run roughly ten or more times faster than the serial clock; with a serial clock half period of at least four system cycles the three-cycle input latency stays hidden.

On the receive side, bits are captured most significant first on each serial clock rising edge while select is low. After the eighth bit, the assembled byte appears on `rx_byte_o` and `rx_valid_o` goes high. The flag is a level, not a pulse: it stays high until the first bit of the following byte is sampled, or until select is released. A register controller downstream must see it fall before it accepts the next byte. On the transmit side, the controller presents a byte with a request; the byte is shifted out on MISO, most significant bit first, and a busy flag covers the whole byte so the controller knows when it may load the next one.

The transmitter has two named states. TX_IDLE is the state after reset and whenever select is high; MISO shifts out zeros. The transition TX_IDLE to TX_SHIFT (load) happens when a request arrives with select low. TX_SHIFT to TX_IDLE (done) happens on the eighth serial clock falling edge after the load. TX_SHIFT to TX_IDLE (abort) happens when select is released.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, `rx_valid_o`, `tx_busy_o` and `miso_o` are 0 and `rx_byte_o` is 0x00.
- R2: While select is low, MOSI is sampled on each serial clock rising edge, most significant bit first. After the eighth rising edge, `rx_byte_o` holds the eight bits and `rx_valid_o` is 1.
- R3: `rx_valid_o` stays 1 and `rx_byte_o` holds its value until the first rising edge of the next byte, at which point `rx_valid_o` becomes 0.
- R4: Releasing select (cs_n_i high) discards a partial byte and clears `rx_valid_o`. The first byte after reselection is assembled from its own eight bits only.
- R5: A `tx_req_i` high with select low in TX_IDLE loads `tx_byte_i` (the load transition). `tx_busy_o` becomes 1, and bit 7 of that byte appears on `miso_o` before the first rising edge.
- R6: Each serial clock falling edge in TX_SHIFT moves the next lower bit onto `miso_o`. The done transition happens on the eighth falling edge, and `tx_busy_o` returns to 0.
- R7: When no byte is loaded, MISO shifts out zeros. While select is high, `miso_o` is 0.
- R8: `tx_req_i` has no effect while `tx_busy_o` is 1. The byte in progress reaches MISO unchanged.
- R9: Releasing select in TX_SHIFT takes the abort transition: `tx_busy_o` drops to 0 and `miso_o` drives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least about 10x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial clock from master (asynchronous) |
| mosi_i | input | 1 | Serial data from master (asynchronous) |
| cs_n_i | input | 1 | Active-low slave select (asynchronous) |
| miso_o | output | 1 | Serial data to master |
| rx_valid_o | output | 1 | Received byte available (level) |
| rx_byte_o | output | 8 | Last completed received byte |
| tx_req_i | input | 1 | Request to load a transmit byte |
| tx_byte_i | input | 8 | Byte to transmit |
| tx_busy_o | output | 1 | A loaded byte is being shifted out |

## Verification
A receive bit counter that drifts out of step shows up on the byte after the error. That byte comes out rotated or with extra bits, and `rx_valid_o` rises on the wrong rising edge, so a full transfer with a known pattern exposes it within eight serial clocks. A transmit state that does not clear on select release leaves `tx_busy_o` high or sends stale bits on MISO. These show up in the first transfer after reselection. A load that does not hold off while busy corrupts the MISO bits of the byte in flight, and this can be seen within that same byte.

// File: rtl/spi_slave_pkg.sv
package spi_slave_pkg;
    typedef enum logic [0:0] {
        TX_IDLE  = 1'b0,
        TX_SHIFT = 1'b1
    } tx_state_e;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
    parameter int              N_LINES = 3,
    parameter int              STAGES  = 2,
    parameter logic [N_LINES-1:0] RST_VAL = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] d_i,
    output logic [N_LINES-1:0] q_o
);
    logic [N_LINES-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_rx_path.sv
module spi_rx_path #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              mosi_s,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] shreg_nx;

    assign shreg_nx = {shreg[BYTE_W-2:0], mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            rx_valid_o <= 1'b0;
            rx_byte_o  <= '0;
        end else if (!cs_act) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            rx_valid_o <= 1'b0;
        end else if (sck_rise) begin
            shreg <= shreg_nx;
            if (bit_cnt == LAST) begin
                bit_cnt    <= '0;
                rx_byte_o  <= shreg_nx;
                rx_valid_o <= 1'b1;
            end else begin
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == '0) rx_valid_o <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/spi_tx_path.sv
module spi_tx_path
    import spi_slave_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sck_fall,
    input  logic              tx_req_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              tx_busy_o,
    output logic              miso_o
);
    localparam int CNT_W = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    tx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  fall_cnt;
    logic [BYTE_W-1:0] txsh;
    logic              load_go;
    logic              done_go;

    assign load_go = (state_q == TX_IDLE) && cs_act && tx_req_i;
    assign done_go = (state_q == TX_SHIFT) && sck_fall && (fall_cnt == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (load_go) state_d = TX_SHIFT;
            TX_SHIFT: if (!cs_act || done_go) state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsh     <= '0;
            fall_cnt <= '0;
        end else if (!cs_act) begin
            txsh     <= '0;
            fall_cnt <= '0;
        end else if (load_go) begin
            txsh     <= tx_byte_i;
            fall_cnt <= '0;
        end else if (sck_fall) begin
            if (done_go) begin
                txsh     <= '0;
                fall_cnt <= '0;
            end else begin
                txsh <= {txsh[BYTE_W-2:0], 1'b0};
                if (state_q == TX_SHIFT) fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        tx_busy_o = (state_q == TX_SHIFT);
        miso_o    = cs_act & txsh[BYTE_W-1];
    end
endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    output logic              miso_o,
    output logic              rx_valid_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    input  logic              tx_req_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic              tx_busy_o
);
    logic [2:0] pins_s;
    logic       sck_s, mosi_s, cs_n_s;
    logic       sck_prev;
    logic       sck_rise, sck_fall, cs_act;

    spi_in_sync #(
        .N_LINES (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({cs_n_i, mosi_i, sck_i}),
        .q_o   (pins_s)
    );

    assign {cs_n_s, mosi_s, sck_s} = pins_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sck_prev <= 1'b0;
        else        sck_prev <= sck_s;
    end

    assign sck_rise = sck_s & ~sck_prev;
    assign sck_fall = ~sck_s & sck_prev;
    assign cs_act   = ~cs_n_s;

    spi_rx_path #(.BYTE_W(BYTE_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_act     (cs_act),
        .sck_rise   (sck_rise),
        .mosi_s     (mosi_s),
        .rx_valid_o (rx_valid_o),
        .rx_byte_o  (rx_byte_o)
    );

    spi_tx_path #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sck_fall  (sck_fall),
        .tx_req_i  (tx_req_i),
        .tx_byte_i (tx_byte_i),
        .tx_busy_o (tx_busy_o),
        .miso_o    (miso_o)
    );
endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_act,
    input logic              sck_rise,
    input logic              sck_fall,
    input logic              rx_valid_o,
    input logic [BYTE_W-1:0] rx_byte_o,
    input logic              tx_req_i,
    input logic              tx_busy_o,
    input logic              miso_o
);
    // R2: the received flag only rises right after a sampled rising edge
    a_r2_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid_o) |-> $past(sck_rise) && $past(cs_act));

    // R3: the byte output only changes together with a new valid flag
    a_r3_byte_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte_o) |-> $rose(rx_valid_o));

    // R4 and R9: select release clears both flags
    a_r4_cs_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_act) |=> !rx_valid_o && !tx_busy_o);

    // R5 and R8: busy only starts after a request
    a_r5_busy_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy_o) |-> $past(tx_req_i));

    // R6: MISO moves only on a falling edge or a load while selected
    a_r6_miso_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_act && $past(cs_act) && !$stable(miso_o)) |-> ($past(sck_fall) || $rose(tx_busy_o)));

    // R7: MISO idle low while deselected
    a_r7_miso_low_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !$past(cs_act)) |-> !miso_o);
endmodule

bind spi_byte_slave spi_byte_slave_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_act     (cs_act),
    .sck_rise   (sck_rise),
    .sck_fall   (sck_fall),
    .rx_valid_o (rx_valid_o),
    .rx_byte_o  (rx_byte_o),
    .tx_req_i   (tx_req_i),
    .tx_busy_o  (tx_busy_o),
    .miso_o     (miso_o)
);

// File: tb/spi_byte_slave_tb.sv
`timescale 1ns/1ps
module spi_byte_slave_tb;
    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
    logic       miso, rx_valid, tx_busy;
    logic [7:0] rx_byte;
    logic       tx_req = 1'b0;
    logic [7:0] tx_byte = 8'h00;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    spi_byte_slave u_dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_n_i(cs_n),
        .miso_o(miso), .rx_valid_o(rx_valid), .rx_byte_o(rx_byte),
        .tx_req_i(tx_req), .tx_byte_i(tx_byte), .tx_busy_o(tx_busy)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // shift the top n bits of mo; mi collects MISO sampled before each rise
    task automatic shift_bits(input logic [7:0] mo, input int n, output logic [7:0] mi);
        mi = 8'h00;
        for (int i = 7; i > 7 - n; i--) begin
            mosi = mo[i];
            wait_n(HALF);
            mi[i] = miso;
            sck = 1'b1;
            wait_n(HALF);
            sck = 1'b0;
        end
        wait_n(HALF);
    endtask

    task automatic select(input logic v);
        cs_n = ~v;
        wait_n(HALF);
    endtask

    task automatic load(input logic [7:0] b);
        tx_byte = b;
        tx_req  = 1'b1;
        wait_n(1);
        tx_req  = 1'b0;
        wait_n(4);
    endtask

    task automatic t_reset();
        check("R1 rx_valid", {7'd0, rx_valid}, 8'h00);
        check("R1 tx_busy",  {7'd0, tx_busy},  8'h00);
        check("R1 miso",     {7'd0, miso},     8'h00);
        check("R1 rx_byte",  rx_byte,          8'h00);
    endtask

    task automatic t_rx_basic();
        logic [7:0] mi;
        select(1);
        shift_bits(8'hA5, 8, mi);
        check("R2 rx_valid after byte", {7'd0, rx_valid}, 8'h01);
        check("R2 rx_byte A5", rx_byte, 8'hA5);
        check("R7 zeros without load", mi, 8'h00);
        shift_bits(8'h3C, 8, mi);
        check("R2 rx_byte 3C", rx_byte, 8'h3C);
    endtask

    task automatic t_rx_hold();
        logic [7:0] mi;
        wait_n(40);
        check("R3 valid held", {7'd0, rx_valid}, 8'h01);
        check("R3 byte held", rx_byte, 8'h3C);
        shift_bits(8'hFF, 1, mi);
        check("R3 valid drops on first bit", {7'd0, rx_valid}, 8'h00);
        check("R3 byte still held", rx_byte, 8'h3C);
        select(0);
    endtask

    task automatic t_partial();
        logic [7:0] mi;
        select(1);
        shift_bits(8'hFF, 3, mi);
        select(0);
        check("R4 valid cleared on release", {7'd0, rx_valid}, 8'h00);
        select(1);
        shift_bits(8'h5A, 8, mi);
        check("R4 fresh byte after reselect", rx_byte, 8'h5A);
        check("R4 valid after fresh byte", {7'd0, rx_valid}, 8'h01);
        select(0);
        check("R4 valid cleared by cs high", {7'd0, rx_valid}, 8'h00);
    endtask

    task automatic t_tx_basic();
        logic [7:0] mi;
        select(1);
        load(8'hC3);
        check("R5 busy after load", {7'd0, tx_busy}, 8'h01);
        check("R5 msb on miso before first rise", {7'd0, miso}, 8'h01);
        shift_bits(8'h96, 8, mi);
        check("R6 miso byte C3", mi, 8'hC3);
        check("R6 busy drops after byte", {7'd0, tx_busy}, 8'h00);
        check("R2 full duplex rx 96", rx_byte, 8'h96);
        shift_bits(8'h00, 8, mi);
        check("R7 zeros after byte", mi, 8'h00);
        load(8'h5E);
        shift_bits(8'h00, 8, mi);
        check("R6 second loaded byte 5E", mi, 8'h5E);
        select(0);
        check("R7 miso low deselected", {7'd0, miso}, 8'h00);
    endtask

    task automatic t_ignore_busy();
        logic [7:0] mi;
        select(1);
        load(8'h81);
        fork
            shift_bits(8'h00, 8, mi);
            begin
                wait_n(3 * 2 * HALF + 4);
                tx_byte = 8'hFF;
                tx_req  = 1'b1;
                wait_n(2);
                tx_req  = 1'b0;
            end
        join
        check("R8 request while busy ignored", mi, 8'h81);
        check("R8 busy idle after byte", {7'd0, tx_busy}, 8'h00);
        select(0);
    endtask

    task automatic t_abort();
        logic [7:0] mi;
        select(1);
        load(8'hAA);
        shift_bits(8'h00, 3, mi);
        check("R9 busy mid byte", {7'd0, tx_busy}, 8'h01);
        select(0);
        check("R9 busy cleared on release", {7'd0, tx_busy}, 8'h00);
        check("R9 miso zero on release", {7'd0, miso}, 8'h00);
        select(1);
        shift_bits(8'h00, 8, mi);
        check("R9 no stale bits after abort", mi, 8'h00);
        select(0);
    endtask

    initial begin
        wait_n(4);
        t_reset();
        rst_n = 1'b1;
        wait_n(4);
        t_reset();
        t_rx_basic();
        t_rx_hold();
        t_partial();
        t_tx_basic();
        t_ignore_busy();
        t_abort();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule